// File: doc/BRIEF.md
# MSI Interrupt Remapping Unit

This unit sits in the path of message-signalled interrupt writes. Each incoming message carries a 64-bit address, 32-bit data and the sender's 16-bit requester ID. The unit first decides whether the write lands in the interrupt window and whether it uses the remappable format. If both hold, it builds a table index from a handle that is spread over several address bits. It then reads the 128-bit table entry from memory, validates the entry against the sender, and emits one remapped interrupt. Any rejected message produces one fault strobe carrying a code.

A static configuration input gives the table's page-aligned base address and its size. Only one message is handled at a time. Messages arrive on a valid/ready interface. `msg_ready` is high only while no message is in flight, and the sender holds `msg_valid` and its fields steady until it sees ready. Table reads go out on a valid/ready request channel: once raised, `rd_req_valid` stays high with a stable `rd_addr` until `rd_req_ready` is seen. The memory returns exactly one response beat per accepted request, at any later cycle, and the unit always accepts that beat. The results are single-cycle strobes with no back-pressure.

Top module: `irq_remap_unit`

## Requirements
- R1: After reset `msg_ready` is 1, and `irq_valid`, `fault_valid` and `rd_req_valid` are all 0.
- R2: A message is an interrupt only if address bits 63:32 are all zero and bits 31:20 equal 0xFEE. Any other message gets fault code 1, and no table read is issued.
- R3: A message inside the window whose address bit 4 is 0 (not the remappable format) gets fault code 2, and no table read is issued.
- R4: The 16-bit handle takes its bits 14:0 from address bits 19:5 and its bit 15 from address bit 2. When address bit 3 is set, the index is the handle plus data bits 15:0, computed 17 bits wide. When bit 3 is clear, the index is the handle alone.
- R5: Configuration bits 3:0 hold a size field s, and the table holds 2^(s+1) entries. An index at or above that count gets fault code 3, and no table read is issued.
- R6: The read address is the configuration value with bits 11:0 cleared, plus index × 16. While `rd_req_ready` is low, `rd_req_valid` stays high, `rd_addr` stays stable and `msg_ready` stays low.
- R7: An entry whose bit 0 (present) is clear gets fault code 4. Otherwise, an entry whose bit 15 (entry mode) is set gets fault code 5. Both checks take priority over the source check.
- R8: The source check uses three fields in entry bits 127:64: bits 15:0 are the source ID, bits 17:16 are the qualifier q, and bits 19:18 are the type t. With t = 0 there is no check. With t = 1 the requester ID must equal the source ID after both are masked: q = 0 compares all 16 bits, q = 1 ignores bit 2, q = 2 ignores bits 2:1, and q = 3 ignores bits 2:0. A mismatch, or t = 2 or t = 3, gets fault code 6.
- R9: An accepted entry gives a one-cycle `irq_valid` strobe. The strobe carries the vector from entry bits 23:16, the destination from bits 63:32, the destination mode from bit 2, the trigger mode from bit 4 and the delivery mode from bits 7:5.
- R10: Each accepted message produces exactly one single-cycle strobe, either `irq_valid` or `fault_valid`, and never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_table | input | ADDR_W | Table base (bits above 11) and size field (bits 3:0) |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Unit idle and able to take a message |
| msg_addr | input | 64 | Message address |
| msg_data | input | 32 | Message data |
| msg_rid | input | 16 | Requester ID of the sender |
| rd_req_valid | output | 1 | Table read request |
| rd_req_ready | input | 1 | Memory takes the request |
| rd_addr | output | ADDR_W | Byte address of the table entry |
| rd_rsp_valid | input | 1 | Entry data beat |
| rd_rsp_data | input | 128 | Table entry |
| irq_valid | output | 1 | Remapped interrupt strobe |
| irq_vector | output | 8 | Interrupt vector |
| irq_dest | output | 32 | Destination ID |
| irq_dest_mode | output | 1 | Destination mode |
| irq_trigger | output | 1 | Trigger mode |
| irq_delivery | output | 3 | Delivery mode |
| fault_valid | output | 1 | Fault strobe |
| fault_code | output | 3 | Fault reason, 1 to 6 |

## Verification
The bench builds the unit with its defaults: a 64-bit table address and 4 KiB page alignment. It reaches every fault path and the bound check by switching the size field at run time. Size field 2 gives eight entries, so handles 8 and above, and a handle plus subhandle that reaches past the end, hit the range fault. Size field 0xF gives 65536 entries, which exposes handle bit 15 and the 17-bit index carry at exactly 65536. The bench also holds the read request off for several cycles to observe back-pressure.

// File: rtl/irq_remap_pkg.sv
package irq_remap_pkg;
  localparam int HANDLE_W    = 16;
  localparam int IDX_W       = HANDLE_W + 1;
  localparam int RID_W       = 16;
  localparam int ENTRY_W     = 128;
  localparam int SIZE_W      = 4;
  localparam logic [11:0] MSI_WINDOW = 12'hFEE;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_WINDOW = 3'd1,
    FLT_COMPAT = 3'd2,
    FLT_RANGE  = 3'd3,
    FLT_ABSENT = 3'd4,
    FLT_MODE   = 3'd5,
    FLT_SOURCE = 3'd6
  } flt_e;

  typedef struct packed {
    logic [7:0]  vector;
    logic [31:0] dest;
    logic        dest_mode;
    logic        trig;
    logic [2:0]  dlv;
  } irq_fields_t;
endpackage

// File: rtl/irq_msg_decode.sv
module irq_msg_decode
  import irq_remap_pkg::*;
(
  input  logic [63:0]       addr,
  input  logic [31:0]       data,
  input  logic [SIZE_W-1:0] size_fld,
  output logic [IDX_W-1:0]  idx,
  output flt_e              fault
);
  localparam int LOW_H = HANDLE_W - 1;

  logic               win_ok;
  logic [HANDLE_W-1:0] handle;
  logic [IDX_W-1:0]    limit;
  logic [SIZE_W:0]     shift_amt;
  logic                unused_dec;

  assign unused_dec = ^{addr[1:0], data[31:16]};

  always_comb begin
    win_ok    = (addr[63:32] == 32'h0) && (addr[31:20] == MSI_WINDOW);
    handle    = {addr[2], addr[5 +: LOW_H]};
    idx       = {1'b0, handle} + (addr[3] ? {1'b0, data[HANDLE_W-1:0]} : '0);
    shift_amt = {1'b0, size_fld} + 1'b1;
    limit     = IDX_W'(1) << shift_amt;
    if (!win_ok)           fault = FLT_WINDOW;
    else if (!addr[4])     fault = FLT_COMPAT;
    else if (idx >= limit) fault = FLT_RANGE;
    else                   fault = FLT_NONE;
  end
endmodule

// File: rtl/irq_entry_check.sv
module irq_entry_check
  import irq_remap_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  input  logic [RID_W-1:0]   rid,
  output flt_e               fault,
  output irq_fields_t        fields
);
  logic [63:0]      lo, hi;
  logic [RID_W-1:0] mask;
  logic             src_ok;
  logic             unused_ent;

  assign lo = entry[63:0];
  assign hi = entry[127:64];
  assign unused_ent = ^{lo[1], lo[3], lo[14:8], lo[31:24], hi[63:20]};

  always_comb begin
    mask = '1;
    for (int b = 0; b < 3; b++)
      if (32'(hi[17:16]) > b) mask[2 - b] = 1'b0;
    case (hi[19:18])
      2'd0:    src_ok = 1'b1;
      2'd1:    src_ok = ((rid ^ hi[RID_W-1:0]) & mask) == '0;
      default: src_ok = 1'b0;
    endcase
    if (!lo[0])       fault = FLT_ABSENT;
    else if (lo[15])  fault = FLT_MODE;
    else if (!src_ok) fault = FLT_SOURCE;
    else              fault = FLT_NONE;
    fields.vector    = lo[23:16];
    fields.dest      = lo[63:32];
    fields.dest_mode = lo[2];
    fields.trig      = lo[4];
    fields.dlv       = lo[7:5];
  end
endmodule

// File: rtl/irq_remap_unit.sv
module irq_remap_unit
  import irq_remap_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cfg_table,
  input  logic                msg_valid,
  output logic                msg_ready,
  input  logic [63:0]         msg_addr,
  input  logic [31:0]         msg_data,
  input  logic [15:0]         msg_rid,
  output logic                rd_req_valid,
  input  logic                rd_req_ready,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic                rd_rsp_valid,
  input  logic [127:0]        rd_rsp_data,
  output logic                irq_valid,
  output logic [7:0]          irq_vector,
  output logic [31:0]         irq_dest,
  output logic                irq_dest_mode,
  output logic                irq_trigger,
  output logic [2:0]          irq_delivery,
  output logic                fault_valid,
  output logic [2:0]          fault_code
);
  localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;

  st_e              state;
  logic [RID_W-1:0] rid_q;
  logic [ADDR_W-1:0] addr_q;
  flt_e             fault_q;
  irq_fields_t      fields_q;

  logic [IDX_W-1:0] dec_idx;
  flt_e             dec_fault;
  flt_e             chk_fault;
  irq_fields_t      chk_fields;
  logic [ADDR_W-1:0] base;
  logic             unused_cfg;

  assign base       = {cfg_table[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign unused_cfg = ^cfg_table[PAGE_SHIFT-1:SIZE_W];

  irq_msg_decode u_dec (
    .addr     (msg_addr),
    .data     (msg_data),
    .size_fld (cfg_table[SIZE_W-1:0]),
    .idx      (dec_idx),
    .fault    (dec_fault)
  );

  irq_entry_check u_chk (
    .entry  (rd_rsp_data),
    .rid    (rid_q),
    .fault  (chk_fault),
    .fields (chk_fields)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      rid_q       <= '0;
      addr_q      <= '0;
      fault_q     <= FLT_NONE;
      fields_q    <= '0;
      irq_valid   <= 1'b0;
      fault_valid <= 1'b0;
    end else begin
      irq_valid   <= 1'b0;
      fault_valid <= 1'b0;
      case (state)
        ST_IDLE: if (msg_valid) begin
          rid_q  <= msg_rid;
          addr_q <= base + (ADDR_W'(dec_idx) << ENTRY_SHIFT);
          if (dec_fault != FLT_NONE) begin
            fault_valid <= 1'b1;
            fault_q     <= dec_fault;
          end else begin
            state <= ST_REQ;
          end
        end
        ST_REQ: if (rd_req_ready) state <= ST_WAIT;
        ST_WAIT: if (rd_rsp_valid) begin
          state <= ST_IDLE;
          if (chk_fault != FLT_NONE) begin
            fault_valid <= 1'b1;
            fault_q     <= chk_fault;
          end else begin
            irq_valid <= 1'b1;
            fields_q  <= chk_fields;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign msg_ready     = (state == ST_IDLE);
  assign rd_req_valid  = (state == ST_REQ);
  assign rd_addr       = addr_q;
  assign fault_code    = fault_q;
  assign irq_vector    = fields_q.vector;
  assign irq_dest      = fields_q.dest;
  assign irq_dest_mode = fields_q.dest_mode;
  assign irq_trigger   = fields_q.trig;
  assign irq_delivery  = fields_q.dlv;

  // R10: one outcome per message, never both strobes together
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid && fault_valid));
  // R9: delivery strobe lasts a single cycle
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);
  // R6: request held with a stable address under back-pressure
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));
  // R6: no new message taken while a read is outstanding
  a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !msg_ready);
  // R2: a read only follows an accepted message
  a_r2_read_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> $past(msg_valid && msg_ready));
endmodule

// File: tb/tb_irq_remap_unit.sv
module tb_irq_remap_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] BASE = 64'h0000_0001_2345_6000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [63:0]  cfg_table;
  logic         msg_valid = 1'b0;
  logic         msg_ready;
  logic [63:0]  msg_addr = '0;
  logic [31:0]  msg_data = '0;
  logic [15:0]  msg_rid = '0;
  logic         rd_req_valid;
  logic         rd_req_ready;
  logic [63:0]  rd_addr;
  logic         rd_rsp_valid;
  logic [127:0] rd_rsp_data;
  logic         irq_valid, irq_dest_mode, irq_trigger, fault_valid;
  logic [7:0]   irq_vector;
  logic [31:0]  irq_dest;
  logic [2:0]   irq_delivery, fault_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_remap_unit dut (
    .clk, .rst_n, .cfg_table, .msg_valid, .msg_ready, .msg_addr, .msg_data,
    .msg_rid, .rd_req_valid, .rd_req_ready, .rd_addr, .rd_rsp_valid,
    .rd_rsp_data, .irq_valid, .irq_vector, .irq_dest, .irq_dest_mode,
    .irq_trigger, .irq_delivery, .fault_valid, .fault_code
  );

  logic [127:0] mem [8];
  int           nreads = 0;
  logic [63:0]  last_addr = '0;
  int           errors = 0;
  int           checks = 0;

  always @(posedge clk) begin
    rd_rsp_valid <= 1'b0;
    if (rd_req_valid && rd_req_ready) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem[3'((rd_addr - BASE) >> 4)];
      last_addr    <= rd_addr;
      nreads       <= nreads + 1;
    end
  end

  function automatic logic [127:0] mk_entry(input logic p, dm, tm,
      input logic [2:0] dlv, input logic mode, input logic [7:0] vec,
      input logic [31:0] dest, input logic [15:0] sid,
      input logic [1:0] q, vt);
    return {44'h0, vt, q, sid,
            dest, 8'h0, vec, mode, 7'h0, dlv, tm, 1'b0, dm, 1'b0, p};
  endfunction

  task automatic check(input string req, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [2:0]  got_code;
  logic [7:0]  got_vec;
  logic [31:0] got_dest;
  logic [4:0]  got_attr;
  int          reads_before;

  task automatic send(input logic [15:0] h, input logic shv, fmt, badw,
      input logic [15:0] d, rid, input logic [31:0] hi);
    @(negedge clk);
    msg_addr  = {hi, badw ? 12'hFED : 12'hFEE, h[14:0], fmt, shv, h[15], 2'b00};
    msg_data  = {16'hA5A5, d};
    msg_rid   = rid;
    msg_valid = 1'b1;
    reads_before = nreads;
    while (!msg_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    msg_valid = 1'b0;
    got_code = 3'h7;
    for (int k = 0; k < 40; k++) begin
      if (irq_valid || fault_valid) begin
        got_code = irq_valid ? 3'd0 : fault_code;
        got_vec  = irq_vector;
        got_dest = irq_dest;
        got_attr = {irq_dest_mode, irq_trigger, irq_delivery};
        break;
      end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [15:0] h; logic shv; logic fmt; logic badw;
    logic [15:0] d; logic [15:0] rid; logic [2:0] code;
    logic [7:0] vec; logic [31:0] dest; logic [4:0] attr; logic [16:0] idx;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{16'h0000, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0108, 3'd0, 8'h30, 32'h11, 5'h00, 17'd0},
    '{16'h0001, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0000, 3'd0, 8'h41, 32'h22, 5'h19, 17'd1},
    '{16'h0000, 1'b1, 1'b1, 1'b0, 16'h7, 16'h0000, 3'd0, 8'h77, 32'hFFFFFFFF, 5'h07, 17'd7},
    '{16'h0002, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0000, 3'd4, 8'h00, 32'h0, 5'h00, 17'd2},
    '{16'h0003, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0000, 3'd5, 8'h00, 32'h0, 5'h00, 17'd3},
    '{16'h0004, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0201, 3'd6, 8'h00, 32'h0, 5'h00, 17'd4},
    '{16'h0004, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0200, 3'd0, 8'h55, 32'h44, 5'h00, 17'd4},
    '{16'h0005, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0317, 3'd0, 8'h66, 32'h55, 5'h02, 17'd5},
    '{16'h0005, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0318, 3'd6, 8'h00, 32'h0, 5'h00, 17'd5},
    '{16'h0006, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0000, 3'd6, 8'h00, 32'h0, 5'h00, 17'd6},
    '{16'h0008, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0000, 3'd3, 8'h00, 32'h0, 5'h00, 17'd8},
    '{16'h0003, 1'b1, 1'b1, 1'b0, 16'h5, 16'h0000, 3'd3, 8'h00, 32'h0, 5'h00, 17'd8},
    '{16'h0001, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0000, 3'd2, 8'h00, 32'h0, 5'h00, 17'd1},
    '{16'h0001, 1'b0, 1'b1, 1'b1, 16'h0, 16'h0000, 3'd1, 8'h00, 32'h0, 5'h00, 17'd1}
  };

  task automatic judge(input string req, input logic [2:0] code,
      input logic [7:0] vec, input logic [31:0] dest, input logic [4:0] attr,
      input logic [16:0] idx);
    check({req, " outcome"}, 64'(got_code), 64'(code));
    if (code == 3'd0) begin
      check("R9 vector", 64'(got_vec), 64'(vec));
      check("R9 dest", 64'(got_dest), 64'(dest));
      check("R9 mode bits", 64'(got_attr), 64'(attr));
    end
    if (code >= 3'd1 && code <= 3'd3)
      check({req, " no read"}, 64'(nreads - reads_before), 64'd0);
    else
      check("R6 entry address", last_addr, BASE + (64'(idx) << 4));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    mem[0] = mk_entry(1, 0, 0, 3'd0, 0, 8'h30, 32'h11, 16'h0108, 2'd0, 2'd1);
    mem[1] = mk_entry(1, 1, 1, 3'd1, 0, 8'h41, 32'h22, 16'h7777, 2'd0, 2'd0);
    mem[2] = mk_entry(0, 0, 0, 3'd0, 1, 8'h99, 32'h0, 16'h0000, 2'd0, 2'd0);
    mem[3] = mk_entry(1, 0, 0, 3'd0, 1, 8'h99, 32'h0, 16'h1234, 2'd0, 2'd1);
    mem[4] = mk_entry(1, 0, 0, 3'd0, 0, 8'h55, 32'h44, 16'h0200, 2'd0, 2'd1);
    mem[5] = mk_entry(1, 0, 0, 3'd2, 0, 8'h66, 32'h55, 16'h0310, 2'd3, 2'd1);
    mem[6] = mk_entry(1, 0, 0, 3'd0, 0, 8'h99, 32'h0, 16'h0000, 2'd0, 2'd2);
    mem[7] = mk_entry(1, 0, 0, 3'd7, 0, 8'h77, 32'hFFFFFFFF, 16'h0000, 2'd0, 2'd0);
    cfg_table    = BASE | 64'h2;
    rd_req_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 msg_ready", 64'(msg_ready), 64'd1);
    check("R1 irq_valid", 64'(irq_valid), 64'd0);
    check("R1 fault_valid", 64'(fault_valid), 64'd0);
    check("R1 rd_req_valid", 64'(rd_req_valid), 64'd0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R7 R8 table walk
    for (int i = 0; i < NV; i++) begin
      send(VT[i].h, VT[i].shv, VT[i].fmt, VT[i].badw, VT[i].d, VT[i].rid, 32'h0);
      judge("R4/R7/R8 vector", VT[i].code, VT[i].vec, VT[i].dest, VT[i].attr, VT[i].idx);
    end

    // R2 nonzero upper address word
    send(16'h0000, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0108, 32'h1);
    judge("R2 high word", 3'd1, 8'h0, 32'h0, 5'h0, 17'd0);

    // R5 R4 full-size table: handle bit 15 and carry to 65536
    cfg_table = BASE | 64'hF;
    send(16'h8000, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0108, 32'h0);
    judge("R4 handle bit 15", 3'd0, 8'h30, 32'h11, 5'h00, 17'h08000);
    send(16'hFFFF, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0000, 32'h0);
    judge("R5 last entry", 3'd0, 8'h77, 32'hFFFFFFFF, 5'h07, 17'h0FFFF);
    send(16'hFFFF, 1'b1, 1'b1, 1'b0, 16'h1, 16'h0000, 32'h0);
    judge("R5 index 65536", 3'd3, 8'h0, 32'h0, 5'h0, 17'h10000);
    cfg_table = BASE | 64'h2;

    // R6 back-pressure on the read request
    rd_req_ready = 1'b0;
    @(negedge clk);
    msg_addr = {32'h0, 12'hFEE, 15'd1, 1'b1, 1'b0, 1'b0, 2'b00};
    msg_rid = 16'h0; msg_valid = 1'b1;
    @(negedge clk);
    msg_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R6 request held", 64'(rd_req_valid), 64'd1);
      check("R6 address", rd_addr, BASE + 64'h10);
      check("R6 busy", 64'(msg_ready), 64'd0);
    end
    rd_req_ready = 1'b1;
    got_code = 3'h7;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (irq_valid) begin got_code = 3'd0; got_vec = irq_vector; break; end
    end
    check("R9 after stall", 64'(got_code), 64'd0);
    check("R9 vector after stall", 64'(got_vec), 64'h41);
    @(negedge clk);
    check("R10 single strobe", 64'(irq_valid), 64'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule